// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Configurable Framing

This block turns a serial input line into characters in a receive buffer. While reception is enabled it waits for a falling edge on the line, which marks a start bit. That edge restarts a bit timer, so each later bit is sampled near its centre. The framing is set by the host. A character has 1 to 8 data bits. Parity can be off, odd or even. A frame ends with one or two stop bits. Data can arrive least-significant bit first or most-significant bit first, and the line level can be inverted before any other processing.

A finished character moves into the receive buffer, and a one-cycle interrupt pulse is raised. Three sticky flags report problems: overrun, framing and parity. They stay set until the host strobes the read input, which also frees the buffer. The bit rate comes from a divider value k: one bit lasts 2*(k+2) clock cycles.

Top module: `uart_rx_core`

## Requirements
- R1: While `rx_en_i` is 0, no frame is received. The state machine stays idle, `irq_o` stays 0 and `full_o` stays 0.
- R2: One bit lasts 2*(`div_i`+2) clock cycles. Each bit is sampled one half bit period after the start-bit falling edge, then once per full bit period after that.
- R3: `char_len_i` holds the character length minus one, covering 1 to 8 bits. Buffer bits at and above that length read as 0.
- R4: With `msb_first_i`=0 the first data bit received goes to bit 0. With `msb_first_i`=1 it goes to bit (length-1), and the last data bit received goes to bit 0.
- R5: With `inv_i`=1 the line is inverted before edge detection and sampling. The idle level on the pin is then 0 and the start bit is 1.
- R6: A character that moves into the empty buffer raises `irq_o` for exactly one cycle and sets `full_o`. A one-cycle `rd_i` strobe clears `full_o`.
- R7: With `par_en_i`=1, one parity bit follows the data bits. `per_o` is set when the XOR of the data bits and the parity bit is not equal to `par_odd_i`, where 1 selects odd parity and 0 selects even parity.
- R8: `fer_o` is set when any of the configured stop bits (one, or two when `two_stop_i`=1) is sampled low after inversion.
- R9: A character that completes while `full_o` is 1 and `rd_i` is 0 is discarded. It sets `ovr_o`, keeps `data_o` unchanged, raises no `irq_o` and changes neither `fer_o` nor `per_o`.
- R10: `ovr_o`, `fer_o` and `per_o` stay set until `rd_i` is strobed, and the strobe clears all three.
- R11: If the line reads high at the middle of the start bit, the frame is dropped as a false start. The receiver goes back to waiting for a falling edge and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| rxd_i | input | 1 | Serial data line |
| div_i | input | DIV_W | Divider value k; one bit lasts 2*(k+2) cycles |
| char_len_i | input | LEN_W | Character length minus one |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | Two stop bits |
| msb_first_i | input | 1 | Bit order select |
| inv_i | input | 1 | Invert the line level |
| rd_i | input | 1 | Host read strobe: frees the buffer and clears the flags |
| data_o | output | DATA_W | Receive buffer |
| full_o | output | 1 | Buffer holds an unread character |
| irq_o | output | 1 | One-cycle receive interrupt |
| ovr_o | output | 1 | Overrun flag |
| fer_o | output | 1 | Framing error flag |
| per_o | output | 1 | Parity error flag |

## Verification
The bench builds the block with its defaults, DATA_W=8 and DIV_W=8. It sweeps every character length, all three parity modes, both stop-bit counts, both bit orders and both polarities, at divider values 1 and 4. At divider 1 a bit lasts only 6 cycles, which puts the synchronizer latency close to the sample point. Parity and stop-bit errors are injected at fixed points in the sweep. Directed frames cover the disabled receiver, a glitch that looks like a start bit but is too short, and a second character that arrives before the first is read, with the flags checked before and after the read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  // inversion ahead of the synchronizer; reset to post-inversion idle level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rxd_i ^ inv_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign fall_o = prev_q & ~s2_q;
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             smp_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic [CNT_W-1:0] reload;

  assign reload = {1'b0, div_i} + CNT_W'(1);

  // cnt runs k+1..0 -> one half bit per wrap; sample on every other wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= reload;
      phase_q <= 1'b0;
    end else if (run_i) begin
      if (cnt_q == '0) begin
        cnt_q   <= reload;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign smp_o = run_i & (cnt_q == '0) & ~phase_q;

  p_smp_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |=> !smp_o);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              lvl_i,
  input  logic              fall_i,
  input  logic              smp_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              msb_first_i,
  output logic              start_o,
  output logic              run_o,
  output logic              done_o,
  output logic [DATA_W-1:0] char_o,
  output logic              fer_o,
  output logic              per_o
);
  rx_state_e         state_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  pos;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              frm_q;
  logic              stop2_q;
  logic              frm_nxt;

  assign start_o = (state_q == ST_IDLE) & rx_en_i & fall_i;
  assign run_o   = (state_q != ST_IDLE);
  assign pos     = msb_first_i ? (char_len_i - idx_q) : idx_q;
  assign frm_nxt = frm_q | ~lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      stop2_q <= 1'b0;
      done_o  <= 1'b0;
      char_o  <= '0;
      fer_o   <= 1'b0;
      per_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!rx_en_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (fall_i) state_q <= ST_START;
          ST_START: if (smp_i) begin
            if (lvl_i) state_q <= ST_IDLE;  // false start
            else begin
              state_q <= ST_DATA;
              idx_q   <= '0;
              shreg_q <= '0;
              par_q   <= 1'b0;
              frm_q   <= 1'b0;
            end
          end
          ST_DATA: if (smp_i) begin
            shreg_q[pos] <= lvl_i;
            par_q        <= par_q ^ lvl_i;
            if (idx_q == char_len_i) begin
              state_q <= par_en_i ? ST_PAR : ST_STOP;
              stop2_q <= two_stop_i;
            end else begin
              idx_q <= idx_q + LEN_W'(1);
            end
          end
          ST_PAR: if (smp_i) begin
            par_q   <= par_q ^ lvl_i;
            state_q <= ST_STOP;
          end
          ST_STOP: if (smp_i) begin
            if (stop2_q) begin
              stop2_q <= 1'b0;
              frm_q   <= frm_nxt;
            end else begin
              done_o  <= 1'b1;
              char_o  <= shreg_q;
              fer_o   <= frm_nxt;
              per_o   <= par_en_i & (par_q != par_odd_i);
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_off_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> state_q == ST_IDLE);

  p_false_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && state_q == ST_START && smp_i && lvl_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              fer_i,
  input  logic              per_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic              per_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, irq_q, ovr_q, fer_q, per_q;
  logic full_eff, ovr_eff, fer_eff, per_eff;

  // read strobe acts first; a same-cycle character then lands in a free buffer
  assign full_eff = full_q & ~rd_i;
  assign ovr_eff  = ovr_q  & ~rd_i;
  assign fer_eff  = fer_q  & ~rd_i;
  assign per_eff  = per_q  & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      full_q <= full_eff;
      ovr_q  <= ovr_eff;
      fer_q  <= fer_eff;
      per_q  <= per_eff;
      if (done_i) begin
        if (full_eff) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= char_i;
          full_q <= 1'b1;
          irq_q  <= 1'b1;
          fer_q  <= fer_eff | fer_i;
          per_q  <= per_eff | per_i;
        end
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign irq_o  = irq_q;
  assign ovr_o  = ovr_q;
  assign fer_o  = fer_q;
  assign per_o  = per_q;

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  p_ovr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_q && !rd_i) |=> ($stable(data_q) && ovr_q && !irq_q));

  p_fer_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fer_q && !rd_i) |=> fer_q);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic              per_o
);
  logic              lvl, fall, smp, start, run, done, c_fer, c_per;
  logic [DATA_W-1:0] chr;

  rx_line_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rxd_i (rxd_i),
    .inv_i (inv_i),
    .lvl_o (lvl),
    .fall_o(fall)
  );

  rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (run),
    .div_i  (div_i),
    .smp_o  (smp)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (rx_en_i),
    .lvl_i      (lvl),
    .fall_i     (fall),
    .smp_i      (smp),
    .char_len_i (char_len_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .msb_first_i(msb_first_i),
    .start_o    (start),
    .run_o      (run),
    .done_o     (done),
    .char_o     (chr),
    .fer_o      (c_fer),
    .per_o      (c_per)
  );

  rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(done),
    .char_i(chr),
    .fer_i (c_fer),
    .per_i (c_per),
    .rd_i  (rd_i),
    .data_o(data_o),
    .full_o(full_o),
    .irq_o (irq_o),
    .ovr_o (ovr_o),
    .fer_o (fer_o),
    .per_o (per_o)
  );
endmodule

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [7:0] div_i = 8'd4;
  logic [2:0] char_len_i = 3'd7;
  logic       par_en_i = 1'b0, par_odd_i = 1'b0, two_stop_i = 1'b0;
  logic       msb_first_i = 1'b0, inv_i = 1'b0, rd_i = 1'b0;
  logic [7:0] data_o;
  logic       full_o, irq_o, ovr_o, fer_o, per_o;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  uart_rx_core dut (.*);

  always @(posedge clk_i) if (irq_o) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int bit_per();
    return 2 * (int'(div_i) + 2);
  endfunction

  task automatic drive(input bit lvl, input int n);
    rxd_i = lvl ^ inv_i;
    repeat (n) @(negedge clk_i);
  endtask

  // bad_par flips parity bit; bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send(input logic [7:0] d, input bit bad_par, input int bad_stop);
    int len;
    int p;
    bit pb;
    len = int'(char_len_i) + 1;
    p = bit_per();
    pb = 1'b0;
    drive(1'b1, 2 * p);
    drive(1'b0, p);
    for (int i = 0; i < len; i++) begin
      int b;
      b = msb_first_i ? (len - 1 - i) : i;
      drive(d[b], p);
      pb ^= d[b];
    end
    if (par_en_i) drive(pb ^ par_odd_i ^ bad_par, p);
    drive(bad_stop != 1, p);
    if (two_stop_i) drive(bad_stop != 2, p);
    drive(1'b1, p);
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R6 reset full", full_o, 0);
    chk("R10 reset flags", {ovr_o, fer_o, per_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: disabled receiver ignores a frame
    begin
      int c0;
      c0 = irq_cnt;
      send(8'hA5, 0, 0);
      chk("R1 no irq when disabled", irq_cnt - c0, 0);
      chk("R1 buffer stays empty", full_o, 0);
    end
    rx_en_i = 1'b1;

    // R2..R8 sweep of all framings
    for (int len = 1; len <= 8; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int ms = 0; ms < 2; ms++)
            for (int iv = 0; iv < 2; iv++) begin
              logic [7:0] d, exp_d;
              bit bp;
              int bs, c0;
              div_i = (len % 2 == 1) ? 8'd1 : 8'd4;
              char_len_i = 3'(len - 1);
              par_en_i = (pm != 0);
              par_odd_i = (pm == 2);
              two_stop_i = st[0];
              msb_first_i = ms[0];
              inv_i = iv[0];
              d = 8'((len * 53 + pm * 29 + st * 7 + ms * 3 + iv * 101) & 255);
              exp_d = 8'(d & ((1 << len) - 1));
              bp = (pm != 0) && ((len + st) % 3 == 0);
              bs = (len == 3 || len == 6) ? (st + 1) : 0;
              drive(1'b1, 2 * bit_per());  // settle after polarity change
              c0 = irq_cnt;
              send(d, bp, bs);
              chk("R6 one irq per char", irq_cnt - c0, 1);
              chk("R6 full set", full_o, 1);
              chk("R2 R3 R4 R5 data", data_o, exp_d);
              chk("R7 parity flag", per_o, bp);
              chk("R8 framing flag", fer_o, bs != 0);
              chk("R9 no overrun", ovr_o, 0);
              do_read();
              chk("R6 read clears full", full_o, 0);
              chk("R10 read clears flags", {ovr_o, fer_o, per_o}, 0);
            end

    div_i = 8'd4; char_len_i = 3'd7; par_en_i = 0; par_odd_i = 0;
    two_stop_i = 0; msb_first_i = 0; inv_i = 0;
    drive(1'b1, 2 * bit_per());

    // R11: glitch shorter than half a bit
    begin
      int c0;
      c0 = irq_cnt;
      drive(1'b0, 3);
      drive(1'b1, 4 * bit_per());
      chk("R11 false start no irq", irq_cnt - c0, 0);
      chk("R11 false start no data", full_o, 0);
      send(8'h3C, 0, 0);
      chk("R11 next frame ok", data_o, 8'h3C);
      do_read();
    end

    // R9 + R10: overrun keeps first char, flags sticky
    begin
      int c0;
      c0 = irq_cnt;
      send(8'h5A, 0, 1);
      send(8'hC3, 0, 0);
      chk("R9 data kept", data_o, 8'h5A);
      chk("R9 ovr set", ovr_o, 1);
      chk("R9 no irq for discarded", irq_cnt - c0, 1);
      repeat (50) @(negedge clk_i);
      chk("R10 fer sticky", fer_o, 1);
      chk("R10 ovr sticky", ovr_o, 1);
      do_read();
      chk("R10 cleared after read", {ovr_o, fer_o, per_o}, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule